// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that owns a small bank of eight 8-bit configuration registers for a clock generator. A system controller reaches the bank with four kinds of transfer: an indexed single-byte write or read, and a sequential block write or read. The command byte that follows the address decides which kind is used. Block transfers carry a byte count. On a write the controller sends the count. On a read the slave sends the count first, and then the data from register 0 upward.

The serial lines arrive as plain inputs sampled by the block's own, faster clock. The slave pulls the data line low through a single open-drain enable. Every register's current read view is exposed on a flat output bus so that downstream clock logic can use it. Register 0 mixes stored control bits with status bits taken from live stop pins and from two frequency-select straps captured during reset. Register 7 is a fixed identifier.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69 (0xD2 with the write bit, 0xD3 with the read bit). For any other address it leaves SDA released, and the bytes that follow in that transfer change no register.
- R2: A command byte with bit 7 = 1 selects single-byte mode, and bits 6:0 give the register offset. The one data byte that follows is written to that register, subject to the writable-bit masks.
- R3: A single-byte read is made up of the command, a repeated start, address 0xD3, and one data byte from the slave. That byte is the read view of the addressed register.
- R4: A command byte with bit 7 = 0 selects block mode, starting at register 0. On a write, the byte after the command is a count. Each data byte after it goes to the next register upward. A stop after any whole byte leaves the later registers unchanged.
- R5: A block read (command 0x00, repeated start, 0xD3) returns the count 8 first, then registers 0 to 7 in ascending order. The transfer ends at the first byte the master does not acknowledge.
- R6: After reset the read views are reg1 = 0x7F, reg2 = 0x00, reg3 = 0xFF, reg4 = 0x47, reg5 = 0xDF and reg6 = 0x03. Bits 7:4 of reg0 are 0100.
- R7: Bits 3:0 of reg0 are read-only, and writes to them are ignored. Bit 3 = PCI stop pin AND reg3 bit 7. Bit 2 = CPU stop pin. Bit 1 = select-B strap and bit 0 = select-A strap, both captured during reset and held afterwards.
- R8: Register 7 always reads 0x48, and writes to it are ignored.
- R9: Writes to offsets 8 and above are ignored. Reads from those offsets return 0xFF.
- R10: Data travels MSB first. The slave changes its SDA enable only while SCL is low.
- R11: A stop condition returns the slave to idle with SDA released. A following transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; the straps are captured while it is high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| pci_stop_n_i | input | 1 | Live PCI stop pin, active low |
| cpu_stop_n_i | input | 1 | Live CPU stop pin, active low |
| sel_a_i | input | 1 | Frequency-select strap A |
| sel_b_i | input | 1 | Frequency-select strap B |
| cfg_o | output | 64 | Read views of registers 0..7; register n sits in bits 8n+7:8n |

## Verification
The bench sweeps every 7-bit address. A slave that decodes too few address bits would acknowledge a neighbour and let its data corrupt register 1. Single-byte writes are swept across offsets 0 to 8 with arithmetically varied data, and each write is read back. This exposes a slave that writes the read-only nibble of register 0 or the identifier, or that stores offset 8 by wrapping it onto register 0. Block transfers are checked both whole and cut short: a slave that ignores the count byte on a write would shift every register by one, and one that skips the count on a read would return data one position early. The live bits of register 0 are toggled from both the PCI stop pin and the software stop bit, which catches an OR where an AND belongs.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int REG_W     = 8;
    localparam int REG_N     = 8;
    localparam int IDX_W     = 7;
    localparam int LIVE_BITS = 4;
    localparam int SW_STOP_REG = 3;
    localparam int SW_STOP_BIT = 7;
    localparam logic [6:0] DEV_ADDR = 7'h69;
    localparam logic [7:0] ID_VALUE = 8'h48;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_TX,
        LS_MACK
    } link_state_t;

    typedef enum logic [1:0] {
        RK_ADDR,
        RK_CMD,
        RK_COUNT,
        RK_DATA
    } rx_kind_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic logic [7:0] reset_value(int idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'h7F;
            2:       return 8'h00;
            3:       return 8'hFF;
            4:       return 8'h47;
            5:       return 8'hDF;
            6:       return 8'h03;
            7:       return ID_VALUE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] write_mask(int idx);
        case (idx)
            0:       return 8'hF0;
            7:       return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic scl_prev;
    logic sda_prev;
    logic scl_s;
    logic sda_s;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_s & ~scl_prev;
        ev_o.scl_fall = ~scl_s & scl_prev;
        ev_o.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        ev_o.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
        ev_o.sda      = sda_s;
    end

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smb_pkg::*;
#(
    parameter int NREG = REG_N,
    parameter int DW   = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output wr_req_t          wr_o,
    output logic             sda_oe_o
);

    link_state_t      state;
    rx_kind_t         kind;
    logic [3:0]       bitcnt;
    logic [DW-1:0]    rx_sh;
    logic [DW-1:0]    tx_sh;
    logic [IDX_W-1:0] ptr;
    logic             to_tx;
    logic             cnt_pending;
    logic             mack_ok;
    logic [DW-1:0]    next_tx;

    assign rd_idx_o = ptr;
    assign next_tx  = cnt_pending ? DW'(NREG) : rd_data_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= LS_IDLE;
            kind        <= RK_ADDR;
            bitcnt      <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            ptr         <= '0;
            to_tx       <= 1'b0;
            cnt_pending <= 1'b0;
            mack_ok     <= 1'b0;
            sda_oe_o    <= 1'b0;
            wr_o        <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (ev_i.start) begin
                state    <= LS_RX;
                kind     <= RK_ADDR;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (ev_i.stop) begin
                state    <= LS_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    LS_RX: begin
                        if (ev_i.scl_rise && bitcnt != 4'd8) begin
                            rx_sh  <= {rx_sh[DW-2:0], ev_i.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev_i.scl_fall && bitcnt == 4'd8) begin
                            state    <= LS_ACK;
                            sda_oe_o <= 1'b1;
                            to_tx    <= 1'b0;
                            case (kind)
                                RK_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        to_tx <= rx_sh[0];
                                        kind  <= RK_CMD;
                                    end else begin
                                        state    <= LS_IDLE;
                                        sda_oe_o <= 1'b0;
                                    end
                                end
                                RK_CMD: begin
                                    ptr         <= rx_sh[7] ? rx_sh[IDX_W-1:0] : '0;
                                    cnt_pending <= ~rx_sh[7];
                                    kind        <= rx_sh[7] ? RK_DATA : RK_COUNT;
                                end
                                RK_COUNT: begin
                                    cnt_pending <= 1'b0;
                                    kind        <= RK_DATA;
                                end
                                default: begin
                                    wr_o.en   <= 1'b1;
                                    wr_o.idx  <= ptr;
                                    wr_o.data <= rx_sh;
                                    if (ptr != '1) ptr <= ptr + 1'b1;
                                end
                            endcase
                        end
                    end
                    LS_ACK: begin
                        if (ev_i.scl_fall) begin
                            bitcnt <= '0;
                            if (to_tx) begin
                                state    <= LS_TX;
                                tx_sh    <= next_tx;
                                sda_oe_o <= ~next_tx[DW-1];
                                if (cnt_pending) cnt_pending <= 1'b0;
                                else if (ptr != '1) ptr <= ptr + 1'b1;
                            end else begin
                                state    <= LS_RX;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    LS_TX: begin
                        if (ev_i.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state    <= LS_MACK;
                                sda_oe_o <= 1'b0;
                                mack_ok  <= 1'b0;
                            end else begin
                                tx_sh    <= {tx_sh[DW-2:0], 1'b0};
                                sda_oe_o <= ~tx_sh[DW-2];
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    LS_MACK: begin
                        if (ev_i.scl_rise) begin
                            mack_ok <= ~ev_i.sda;
                        end else if (ev_i.scl_fall) begin
                            if (mack_ok) begin
                                state    <= LS_TX;
                                bitcnt   <= '0;
                                tx_sh    <= next_tx;
                                sda_oe_o <= ~next_tx[DW-1];
                                if (cnt_pending) cnt_pending <= 1'b0;
                                else if (ptr != '1) ptr <= ptr + 1'b1;
                            end else begin
                                state <= LS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int NREG = REG_N,
    parameter int DW   = REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [DW-1:0]      rd_data_o,
    input  logic               pci_stop_n_i,
    input  logic               cpu_stop_n_i,
    input  logic               sel_a_i,
    input  logic               sel_b_i,
    output logic [NREG*DW-1:0] view_o
);

    logic [NREG*DW-1:0] held;
    logic sel_a_q;
    logic sel_b_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] MASK = DW'(write_mask(g));
        localparam logic [DW-1:0] INIT = DW'(reset_value(g));
        if (MASK == '0) begin : g_const
            assign held[g*DW +: DW] = INIT;
        end else begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= INIT;
                end else if (wr_i.en && wr_i.idx == IDX_W'(g)) begin
                    q <= (q & ~MASK) | (wr_i.data & MASK);
                end
            end
            assign held[g*DW +: DW] = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_a_q <= sel_a_i;
            sel_b_q <= sel_b_i;
        end
    end

    always_comb begin
        view_o = held;
        view_o[LIVE_BITS-1:0] = {pci_stop_n_i & held[SW_STOP_REG*DW + SW_STOP_BIT],
                                 cpu_stop_n_i, sel_b_q, sel_a_q};
    end

    always_comb begin
        rd_data_o = '1;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx_i == IDX_W'(i)) rd_data_o = view_o[i*DW +: DW];
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_pkg::*;
#(
    parameter int NREG = REG_N,
    parameter int DW   = REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic               pci_stop_n_i,
    input  logic               cpu_stop_n_i,
    input  logic               sel_a_i,
    input  logic               sel_b_i,
    output logic [NREG*DW-1:0] cfg_o
);

    line_ev_t         ev;
    wr_req_t          wr;
    logic [IDX_W-1:0] rd_idx;
    logic [DW-1:0]    rd_data;

    smb_line_sync #(.SYNC_STAGES(2)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    smb_link #(.NREG(NREG), .DW(DW)) link_i (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .rd_data_i (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_o      (wr),
        .sda_oe_o  (sda_oe_o)
    );

    smb_regbank #(.NREG(NREG), .DW(DW)) bank_i (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (wr),
        .rd_idx_i     (rd_idx),
        .rd_data_o    (rd_data),
        .pci_stop_n_i (pci_stop_n_i),
        .cpu_stop_n_i (cpu_stop_n_i),
        .sel_a_i      (sel_a_i),
        .sel_b_i      (sel_b_i),
        .view_o       (cfg_o)
    );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter int NREG = 8,
    parameter int DW   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               sda_i,
    input logic               sda_oe_o,
    input logic [NREG*DW-1:0] cfg_o
);

    // R10: the slave moves SDA only while SCL is low
    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !$past(scl_i));

    // R2: stored register bits change only in the low phase of SCL
    assert_write_in_low_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_o[NREG*DW-1:DW]) || !$stable(cfg_o[DW-1:4])) |-> !$past(scl_i));

    // R7: the captured straps hold once reset has been released
    assert_straps_held_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_o[1:0]));

    // R11: a stop on the bus leaves SDA released
    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |-> ##3 !sda_oe_o);

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .DW(DW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o)
);

// File: tb/smb_cfg_slave_tb_top.sv
module smb_cfg_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WD_CYCLES  = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic pci_n = 1'b1;
    logic cpu_n = 1'b1;
    logic sel_a = 1'b1;
    logic sel_b = 1'b0;
    logic [63:0] cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] model [8];
    localparam logic SEL_A_L = 1'b1;
    localparam logic SEL_B_L = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_cfg_slave dut_i (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .pci_stop_n_i (pci_n),
        .cpu_stop_n_i (cpu_n),
        .sel_a_i      (sel_a),
        .sel_b_i      (sel_b),
        .cfg_o        (cfg)
    );

    function automatic logic [7:0] wmask(int i);
        return (i == 0) ? 8'hF0 : (i == 7) ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_view(int i);
        if (i == 0) return {model[0][7:4], pci_n & model[3][7], cpu_n, SEL_B_L, SEL_A_L};
        if (i < 8) return model[i];
        return 8'hFF;
    endfunction

    function automatic void model_write(int i, logic [7:0] v);
        if (i < 8) model[i] = (model[i] & ~wmask(i)) | (v & wmask(i));
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(HALF);
        scl_m = 1'b1; wait_clks(HALF);
        sda_m = 1'b0; wait_clks(HALF);
        scl_m = 1'b0; wait_clks(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(HALF);
        scl_m = 1'b1; wait_clks(HALF);
        sda_m = 1'b1; wait_clks(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clks(HALF);
            scl_m = 1'b1; wait_clks(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_clks(HALF);
        scl_m = 1'b1; wait_clks(HALF/2);
        nack = sda_line;
        wait_clks(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic rd_byte(input logic send_nack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wait_clks(HALF);
            scl_m = 1'b1; wait_clks(HALF/2);
            b = {b[6:0], sda_line};
            wait_clks(HALF/2);
            scl_m = 1'b0;
        end
        sda_m = send_nack; wait_clks(HALF);
        scl_m = 1'b1; wait_clks(HALF);
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic byte_write(int off, logic [7:0] v);
        logic nk;
        bus_start();
        wr_byte(8'hD2, nk);
        wr_byte({1'b1, 7'(off)}, nk);
        wr_byte(v, nk);
        bus_stop();
    endtask

    task automatic byte_read(int off, output logic [7:0] v);
        logic nk;
        bus_start();
        wr_byte(8'hD2, nk);
        wr_byte({1'b1, 7'(off)}, nk);
        bus_start();
        wr_byte(8'hD3, nk);
        rd_byte(1'b1, v);
        bus_stop();
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] cnt;
        logic nk;
        model[0] = 8'h40; model[1] = 8'h7F; model[2] = 8'h00; model[3] = 8'hFF;
        model[4] = 8'h47; model[5] = 8'hDF; model[6] = 8'h03; model[7] = 8'h48;

        wait_clks(5);
        rst = 1'b0;
        wait_clks(4);

        // R6 / R8 / R7: reset views
        for (int i = 0; i < 8; i++) chk("R6 reset view", cfg[i*8 +: 8], exp_view(i));
        chk("R8 id value", cfg[63:56], 8'h48);
        chk("R11 idle SDA released", {7'd0, sda_oe}, 8'h00);

        // R7: straps held after reset
        sel_a = 1'b0; sel_b = 1'b1;
        wait_clks(4);
        chk("R7 straps held", cfg[7:0], exp_view(0));

        // R3 / R9 / R10: single-byte reads over all offsets
        for (int off = 0; off < 10; off++) begin
            byte_read(off, v);
            chk((off < 8) ? "R3 R10 byte read" : "R9 read beyond bank", v, exp_view(off));
        end

        // R2 / R7 / R8 / R9: single-byte writes swept over offsets
        for (int off = 0; off < 9; off++) begin
            logic [7:0] wv;
            wv = 8'(off * 59 + 90);
            byte_write(off, wv);
            model_write(off, wv);
            byte_read(off, v);
            chk((off == 0) ? "R7 ro nibble" : (off == 7) ? "R8 id ro" :
                (off == 8) ? "R9 write beyond bank" : "R2 byte write", v, exp_view(off));
            if (off == 8) chk("R9 reg0 untouched", cfg[7:0], exp_view(0));
        end

        // R1: address sweep
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wr_byte({7'(a), 1'b0}, nk);
            chk("R1 address match", {7'd0, nk}, (a == 8'h69) ? 8'h00 : 8'h01);
            if (a != 8'h69) begin
                wr_byte(8'h81, nk);
                wr_byte(8'h00, nk);
            end
            bus_stop();
        end
        chk("R1 foreign data ignored", cfg[15:8], exp_view(1));

        // R4: block write of three bytes then stop
        bus_start();
        wr_byte(8'hD2, nk);
        wr_byte(8'h00, nk);
        wr_byte(8'h03, nk);
        wr_byte(8'h9C, nk); model_write(0, 8'h9C);
        wr_byte(8'h11, nk); model_write(1, 8'h11);
        wr_byte(8'hE7, nk); model_write(2, 8'hE7);
        bus_stop();
        wait_clks(4);
        for (int i = 0; i < 8; i++) chk("R4 block write", cfg[i*8 +: 8], exp_view(i));

        // R5: full block read
        bus_start();
        wr_byte(8'hD2, nk);
        wr_byte(8'h00, nk);
        bus_start();
        wr_byte(8'hD3, nk);
        rd_byte(1'b0, cnt);
        chk("R5 count byte", cnt, 8'h08);
        for (int i = 0; i < 8; i++) begin
            rd_byte(i == 7, v);
            chk("R5 block read data", v, exp_view(i));
        end
        bus_stop();
        wait_clks(4);
        chk("R11 released after stop", {7'd0, sda_oe}, 8'h00);

        // R5 / R11: block read cut short, then a normal read
        bus_start();
        wr_byte(8'hD2, nk);
        wr_byte(8'h00, nk);
        bus_start();
        wr_byte(8'hD3, nk);
        rd_byte(1'b0, cnt);
        rd_byte(1'b0, v);
        chk("R5 partial first", v, exp_view(0));
        rd_byte(1'b1, v);
        chk("R5 partial second", v, exp_view(1));
        bus_stop();
        byte_read(5, v);
        chk("R11 recovery read", v, exp_view(5));

        // R7: live stop bits
        pci_n = 1'b0; wait_clks(2);
        byte_read(0, v);
        chk("R7 pci pin low", v, exp_view(0));
        pci_n = 1'b1;
        byte_write(3, 8'h7F); model_write(3, 8'h7F);
        byte_read(0, v);
        chk("R7 sw stop bit low", v, exp_view(0));
        chk("R7 bit3 zero", {7'd0, v[3]}, 8'h00);
        byte_write(3, 8'hFF); model_write(3, 8'hFF);
        cpu_n = 1'b0; wait_clks(2);
        byte_read(0, v);
        chk("R7 cpu pin low", v, exp_view(0));
        chk("R7 bit3 restored", {7'd0, v[3]}, 8'h01);
        cpu_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule